// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Chain

This block resolves which of several devices sharing one interrupt level is served when the processor acknowledges that level. An acknowledge enters at the cell nearest the processor and passes from cell to cell in position order. A cell with no pending request lets the acknowledge through unchanged. The first cell in chain order that has a pending request absorbs the acknowledge. It then drives its own fixed interrupt vector onto the shared data lines, and later cells never see the acknowledge.

Once a cell has taken the acknowledge, the chain is locked to it. It keeps the grant while its request and the acknowledge both stay high, even if a cell nearer the processor raises a new request in the meantime. The wrapper holds a table-base register. From the base and the vector now driven it forms the address of the handler-table entry: base plus four times the vector, because each entry is four bytes wide.

The vector and the entry address are plain level outputs qualified by `vec_valid`. Nothing downstream can stall them, so there is no back-pressure. The acknowledge chain itself is combinational. The grant is captured in one register per cell.

Top module: `iack_vec_chain`

## Requirements
- R1: With no request pending in any cell, `iack_tail` equals `iack_in` in the same cycle and no cell takes the grant.
- R2: When a cell has a pending request and the acknowledge reaches it, the acknowledge does not pass beyond it: `iack_tail` is 0 in that same cycle and for as long as any cell holds the grant.
- R3: On a clock edge with `iack_in` high, no grant held and any requests pending, the grant goes to the pending cell with the lowest index, where cell 0 is nearest the processor. From the following cycle `drive_en` has only that bit set.
- R4: A cell holding the grant keeps it on every edge where its request and `iack_in` are both high, whatever requests the other cells raise.
- R5: On the edge where the holding cell's request is seen low, the grant is released. On the next edge with `iack_in` high, the lowest-index cell still requesting takes the grant. This leaves one cycle with no grant between the two holders.
- R6: At most one bit of `drive_en` is set. `vec_valid` is high exactly when one bit is set. `vec_data` equals the holding cell's vector taken from `dev_vec` (cell i at bits i*VW +: VW), and is 0 when no grant is held.
- R7: `entry_addr` equals the stored base plus `vec_data` times 4, modulo 2^AW. Its two low bits are always 0.
- R8: A cycle with `base_load` high stores `base_in` with its two low bits cleared, and the new base is used from the next cycle. Reset clears the base to 0.
- R9: After reset, no grant is held: `drive_en` = 0, `vec_valid` = 0, `vec_data` = 0 and `entry_addr` = 0.
- R10: An edge where `iack_in` is low releases any held grant, and no grant is held in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iack_in | input | 1 | Acknowledge entering the cell nearest the processor |
| dev_req | input | N | Pending request of each cell, bit 0 nearest the processor |
| dev_vec | input | N*VW | Fixed vector of each cell, cell i at bits i*VW +: VW |
| base_load | input | 1 | Load strobe for the table-base register |
| base_in | input | AW | Table-base value to load |
| iack_tail | output | 1 | Acknowledge leaving the last cell |
| drive_en | output | N | Per-cell data-line drive enable, set while that cell holds the grant |
| vec_valid | output | 1 | A cell holds the grant and `vec_data` is driven |
| vec_data | output | VW | Vector on the shared data lines |
| entry_addr | output | AW | Handler-table entry address |

## Verification
The embedded properties check the following on every cycle: the drive enables stay one-hot or idle, the chain tail stays quiet while a grant is held, a holder keeps its grant while its request and the acknowledge persist, an absent acknowledge clears the grant, and entry addresses stay 4-byte aligned. Only the bench scenarios show which cell wins. It sweeps every request pattern of the four-cell chain against two base values and compares against the lowest set bit. The bench scenarios also cover the one-cycle gap on hand-over, the exact address arithmetic including wrap-around, and the masking of base low bits.

// File: rtl/iack_vec_pkg.sv
package iack_vec_pkg;
  // Each handler-table entry is four bytes wide.
  localparam int unsigned ENTRY_SHIFT = 2;

  // Mask that clears the sub-entry bits of an address of width w.
  function automatic logic [63:0] align_mask(input int unsigned w);
    logic [63:0] m;
    m = '1;
    m[ENTRY_SHIFT-1:0] = '0;
    if (w < 64) m = m & ((64'd1 << w) - 64'd1);
    return m;
  endfunction
endpackage

// File: rtl/iack_cell.sv
module iack_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_in,
  input  logic req,
  input  logic chain_busy,
  output logic ack_out,
  output logic hold
);
  logic held_q;
  logic absorb;
  logic held_d;

  // A holder absorbs; an idle requester absorbs only when the chain is free.
  assign absorb  = held_q | (req & ~chain_busy);
  assign ack_out = ack_in & ~absorb;
  assign held_d  = ack_in & req & (held_q | ~chain_busy);

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= held_d;
  end

  assign hold = held_q;

  // R2
  cell_absorb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !chain_busy) |-> !ack_out);
endmodule

// File: rtl/vec_merge.sv
module vec_merge #(
  parameter int unsigned N  = 4,
  parameter int unsigned VW = 8
) (
  input  logic [N-1:0]    hold,
  input  logic [N*VW-1:0] vecs,
  output logic [VW-1:0]   vec_out,
  output logic            any_hold
);
  logic [VW-1:0] masked [N];

  for (genvar i = 0; i < N; i++) begin : g_mask
    assign masked[i] = hold[i] ? vecs[i*VW +: VW] : '0;
  end

  always_comb begin
    vec_out = '0;
    for (int i = 0; i < N; i++) vec_out = vec_out | masked[i];
  end

  assign any_hold = |hold;
endmodule

// File: rtl/entry_addr_gen.sv
module entry_addr_gen #(
  parameter int unsigned AW = 16,
  parameter int unsigned VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base_in,
  input  logic [VW-1:0] vec,
  output logic [AW-1:0] addr
);
  import iack_vec_pkg::*;

  localparam logic [AW-1:0] ALIGN = AW'(align_mask(AW));

  logic [AW-1:0] base_q;
  logic [AW-1:0] scaled;

  always_ff @(posedge clk) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= base_in & ALIGN;
  end

  assign scaled = AW'({vec, {ENTRY_SHIFT{1'b0}}});
  assign addr   = base_q + scaled;

  // R7
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr[ENTRY_SHIFT-1:0] == '0);
endmodule

// File: rtl/iack_vec_chain.sv
module iack_vec_chain #(
  parameter int unsigned N  = 4,
  parameter int unsigned VW = 8,
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iack_in,
  input  logic [N-1:0]  dev_req,
  input  logic [N*VW-1:0] dev_vec,
  input  logic          base_load,
  input  logic [AW-1:0] base_in,
  output logic          iack_tail,
  output logic [N-1:0]  drive_en,
  output logic          vec_valid,
  output logic [VW-1:0] vec_data,
  output logic [AW-1:0] entry_addr
);
  logic [N:0]   ack_chain;
  logic [N-1:0] hold;
  logic         busy;

  assign ack_chain[0] = iack_in;
  assign busy         = |hold;

  for (genvar i = 0; i < N; i++) begin : g_cell
    iack_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .ack_in     (ack_chain[i]),
      .req        (dev_req[i]),
      .chain_busy (busy),
      .ack_out    (ack_chain[i+1]),
      .hold       (hold[i])
    );
  end

  assign iack_tail = ack_chain[N];
  assign drive_en  = hold;

  vec_merge #(.N(N), .VW(VW)) u_merge (
    .hold     (hold),
    .vecs     (dev_vec),
    .vec_out  (vec_data),
    .any_hold (vec_valid)
  );

  entry_addr_gen #(.AW(AW), .VW(VW)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (base_load),
    .base_in (base_in),
    .vec     (vec_data),
    .addr    (entry_addr)
  );

  // R6
  single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drive_en));

  // R6
  valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid == (drive_en != '0));

  // R2
  tail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en != '0) |-> !iack_tail);

  // R4
  grant_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((drive_en & dev_req) != '0 && iack_in) |=> drive_en == $past(drive_en));

  // R10
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iack_in |=> !vec_valid);
endmodule

// File: tb/iack_vec_chain_bench.sv
`timescale 1ns/1ps
module iack_vec_chain_bench;
  localparam int N = 4, VW = 8, AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iack_in = 1'b0;
  logic [N-1:0] dev_req = '0;
  logic [N*VW-1:0] dev_vec;
  logic base_load = 1'b0;
  logic [AW-1:0] base_in = '0;
  logic iack_tail, vec_valid;
  logic [N-1:0] drive_en;
  logic [VW-1:0] vec_data;
  logic [AW-1:0] entry_addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  iack_vec_chain #(.N(N), .VW(VW), .AW(AW)) u_iack_vec_chain (
    .clk(clk), .rst_n(rst_n), .iack_in(iack_in), .dev_req(dev_req),
    .dev_vec(dev_vec), .base_load(base_load), .base_in(base_in),
    .iack_tail(iack_tail), .drive_en(drive_en), .vec_valid(vec_valid),
    .vec_data(vec_data), .entry_addr(entry_addr)
  );

  function automatic logic [VW-1:0] vec_of(input int i);
    return VW'(8'h18 + 8'h25 * i);
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_vec
    assign dev_vec[g*VW +: VW] = vec_of(g);
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_base(input logic [AW-1:0] b);
    base_in = b; base_load = 1'b1;
    tick();
    base_load = 1'b0;
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input logic [VW-1:0] v);
    return AW'((int'(b & ~16'h3) + int'(v) * 4) % (1 << AW));
  endfunction

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] bases [2];
    bases[0] = 16'h0263;
    bases[1] = 16'hFFF1;
    @(negedge clk);
    tick();
    rst_n = 1'b1;
    #1;
    // R9 reset state
    chk(drive_en == '0, "R9 drive_en", drive_en, 0);
    chk(!vec_valid, "R9 vec_valid", vec_valid, 0);
    chk(vec_data == '0, "R9 vec_data", vec_data, 0);
    chk(entry_addr == '0, "R9 entry_addr", entry_addr, 0);

    // R1 pass-through with nothing pending
    @(negedge clk);
    iack_in = 1'b1; #1;
    chk(iack_tail == 1'b1, "R1 tail high", iack_tail, 1);
    iack_in = 1'b0; #1;
    chk(iack_tail == 1'b0, "R1 tail low", iack_tail, 0);
    iack_in = 1'b1;
    tick();
    chk(!vec_valid, "R1 no grant", vec_valid, 0);
    chk(iack_tail == 1'b1, "R1 tail still high", iack_tail, 1);

    // R8 base load with low bits dropped, plus R7/R3 full sweep
    foreach (bases[b]) begin
      load_base(bases[b]);
      for (int p = 1; p < (1 << N); p++) begin
        int first;
        iack_in = 1'b0; dev_req = '0;
        tick();
        first = 0;
        for (int k = N - 1; k >= 0; k--) if (p[k]) first = k;
        dev_req = N'(p); iack_in = 1'b1; #1;
        chk(iack_tail == 1'b0, "R2 tail absorbed", iack_tail, 0);
        tick();
        chk(drive_en == N'(1 << first), "R3 winner", drive_en, 1 << first);
        chk(vec_valid, "R6 valid", vec_valid, 1);
        chk(vec_data == vec_of(first), "R6 vector", vec_data, vec_of(first));
        chk(entry_addr == exp_addr(bases[b], vec_of(first)), "R7 R8 entry address",
            entry_addr, exp_addr(bases[b], vec_of(first)));
      end
    end

    // R7 worked example: base 0x260, vector 0x18 gives 0x2C0
    iack_in = 1'b0; dev_req = '0;
    tick();
    load_base(16'h0260);
    dev_req = 4'b0001; iack_in = 1'b1;
    tick();
    chk(entry_addr == 16'h02C0, "R7 example", entry_addr, 16'h02C0);

    // R4 sticky grant against a new earlier request
    iack_in = 1'b0; dev_req = '0;
    tick();
    dev_req = 4'b1000; iack_in = 1'b1;
    tick();
    chk(drive_en == 4'b1000, "R4 initial holder", drive_en, 4'b1000);
    dev_req = 4'b1010;
    tick();
    chk(drive_en == 4'b1000, "R4 holder kept", drive_en, 4'b1000);
    chk(iack_tail == 1'b0, "R2 tail while held", iack_tail, 0);
    tick();
    chk(drive_en == 4'b1000, "R4 holder kept again", drive_en, 4'b1000);

    // R5 hand-over after the holder drops its request
    dev_req = 4'b0010;
    tick();
    chk(!vec_valid, "R5 gap cycle", vec_valid, 0);
    tick();
    chk(drive_en == 4'b0010, "R5 next holder", drive_en, 4'b0010);
    chk(vec_data == vec_of(1), "R5 next vector", vec_data, vec_of(1));

    // R10 acknowledge removed releases the holder
    iack_in = 1'b0;
    tick();
    chk(!vec_valid, "R10 released", vec_valid, 0);
    chk(drive_en == '0, "R10 no drive", drive_en, 0);
    chk(entry_addr == 16'h0260, "R7 idle address", entry_addr, 16'h0260);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule